// File: doc/BRIEF.md
# Charge Summing and Hit Allocation Arbiter

This block decides, once per clock, whether a centre pixel may claim a hit that several neighbouring pixels saw at the same time. It receives a 5x5 grid of digitised charges and above-threshold flags around the centre pixel. It takes a 3x3 window from that grid. The centre pixel claims the hit only when it holds the largest charge among the hit pixels of that window. A claimed hit is not valued by the centre's own charge. Instead the block adds the four 2x2 groups that share a corner with the centre, keeps the largest of those sums, and compares it against a programmable summing threshold.

Two mode inputs alter the behaviour. In single-pixel mode the arbitration and summing are bypassed, and the centre reports its own threshold crossing. In coarse mode only every second pixel of the grid is treated as connected to the sensor. The window then spans the full 5x5 grid at a stride of two, so the summing area doubles in each direction.

Inside the block, stage one classifies the cycle into an enumerated allocation state:
- `CLS_NONE`: no hit is claimed.
- `CLS_SUMMED`: the centre won and summing is used.
- `CLS_SINGLE`: bypass mode is on and the centre flag is set.

The transition into each state is taken afresh every valid cycle, and any cycle with valid low goes to `CLS_NONE`. Stage two turns the registered state into the registered outputs.

Top module: `csa_alloc_arbiter`

## Requirements
- R1: After reset, and until the first result, `hit_strobe`, `hit_corner`, `hit_sum` and `hit_over_thr` are all zero.
- R2: In summing mode the centre claims the hit only when its flag is set and its charge exceeds the charge of every hit neighbour. A larger hit neighbour suppresses the strobe.
- R3: Equal charges are resolved by raster index in the 3x3 window (0 top-left … 8 bottom-right, centre 4). A hit neighbour with a lower index and equal charge beats the centre. The centre beats an equal neighbour with a higher index.
- R4: A neighbour whose flag is low takes no part in the comparison and adds zero to every corner sum, whatever its charge.
- R5: Each corner sum adds the 2x2 group that shares that corner with the centre: top-left uses window indices 0,1,3,4; top-right 1,2,4,5; bottom-left 3,4,6,7; bottom-right 4,5,7,8. `hit_sum` reports the largest of the four, 10 bits wide.
- R6: `hit_corner` encodes top-left 0, top-right 1, bottom-left 2, bottom-right 3. Equal sums resolve to the lowest code.
- R7: In summing mode `hit_over_thr` is 1 exactly when `hit_sum` is greater than or equal to `sum_thr`.
- R8: With `single_mode` high the strobe equals the centre flag regardless of the neighbours. `hit_sum` is then the centre charge, `hit_corner` is 0 and `hit_over_thr` is 1.
- R9: The grid is indexed by row*5+column. With `coarse_mode` low the window is rows and columns 1..3. With it high the window is rows and columns 0, 2 and 4.
- R10: Outputs appear two clocks after the inputs are sampled with `in_valid` high. A cycle with `in_valid` low never produces a strobe.
- R11: Whenever `hit_strobe` is low, `hit_corner`, `hit_sum` and `hit_over_thr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Grid inputs are valid this cycle |
| single_mode | input | 1 | Bypass arbitration and summing |
| coarse_mode | input | 1 | Stride-two window over the grid |
| sum_thr | input | 10 | Summing threshold |
| grid_chg | input | 200 | 25 charges of 8 bits, index row*5+column |
| grid_hit | input | 25 | Above-threshold flags, same indexing |
| hit_strobe | output | 1 | Centre pixel is allocated the hit |
| hit_corner | output | 2 | Winning corner code |
| hit_sum | output | 10 | Winning corner sum, or centre charge in bypass |
| hit_over_thr | output | 1 | Sum reaches the threshold |

## Verification
Some properties are checked every cycle by assertions:
- No strobe appears without a valid input two cycles earlier.
- The outputs stay quiet whenever there is no strobe.
- A winning corner is never beaten by a corner earlier in the tie order.
- The reported best sum is never below any corner sum.
- A winning centre always has its flag set.
- The threshold flag follows the reported sum.

Other behaviours can only be shown by the bench's scenarios:
- The exact tie outcomes on charge.
- The masking of unflagged neighbours with large charges.
- The choice between the inner and stride-two windows.
- The bypass values.
- The exact threshold boundary.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int WIN    = 3;
    localparam int WIN_N  = WIN * WIN;
    localparam int GRID   = 2 * WIN - 1;
    localparam int GRID_N = GRID * GRID;
    localparam int CTR    = WIN_N / 2;
    localparam int N_CORN = 4;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_SUMMED = 2'd1,
        CLS_SINGLE = 2'd2
    } alloc_cls_e;
endpackage

// File: rtl/csa_window_sel.sv
module csa_window_sel
    import csa_pkg::*;
#(
    parameter int CHG_W = 8
) (
    input  logic                      coarse_mode,
    input  logic [GRID_N*CHG_W-1:0]   grid_chg,
    input  logic [GRID_N-1:0]         grid_hit,
    output logic [CHG_W-1:0]          win_chg [WIN_N],
    output logic                      win_hit [WIN_N]
);
    for (genvar wr = 0; wr < WIN; wr++) begin : g_row
        for (genvar wc = 0; wc < WIN; wc++) begin : g_col
            localparam int FINE_IX   = (wr + 1) * GRID + (wc + 1);
            localparam int COARSE_IX = (2 * wr) * GRID + (2 * wc);
            logic             flag;
            logic [CHG_W-1:0] raw;
            always_comb begin
                if (coarse_mode) begin
                    flag = grid_hit[COARSE_IX];
                    raw  = grid_chg[COARSE_IX*CHG_W +: CHG_W];
                end else begin
                    flag = grid_hit[FINE_IX];
                    raw  = grid_chg[FINE_IX*CHG_W +: CHG_W];
                end
                win_hit[wr*WIN+wc] = flag;
                win_chg[wr*WIN+wc] = flag ? raw : '0;
            end
        end
    end
endmodule

// File: rtl/csa_local_max.sv
module csa_local_max
    import csa_pkg::*;
#(
    parameter int CHG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHG_W-1:0] win_chg [WIN_N],
    input  logic             win_hit [WIN_N],
    output logic             centre_wins
);
    always_comb begin
        centre_wins = win_hit[CTR];
        for (int j = 0; j < WIN_N; j++) begin
            if (j < CTR && win_hit[j] && win_chg[j] >= win_chg[CTR])
                centre_wins = 1'b0;
            if (j > CTR && win_hit[j] && win_chg[j] > win_chg[CTR])
                centre_wins = 1'b0;
        end
    end

    p_win_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        centre_wins |-> win_hit[CTR]);
endmodule

// File: rtl/csa_corner_sum.sv
module csa_corner_sum
    import csa_pkg::*;
#(
    parameter int CHG_W = 8,
    parameter int SUM_W = CHG_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHG_W-1:0] win_chg [WIN_N],
    output logic [1:0]       best_idx,
    output logic [SUM_W-1:0] best_sum
);
    logic [SUM_W-1:0] corner [N_CORN];

    for (genvar k = 0; k < N_CORN; k++) begin : g_corner
        localparam int R0 = k / 2;
        localparam int C0 = k % 2;
        localparam int A  = R0 * WIN + C0;
        assign corner[k] = SUM_W'(win_chg[A]) + SUM_W'(win_chg[A+1])
                         + SUM_W'(win_chg[A+WIN]) + SUM_W'(win_chg[A+WIN+1]);
    end

    always_comb begin
        best_idx = 2'd0;
        best_sum = corner[0];
        for (int k = 1; k < N_CORN; k++) begin
            if (corner[k] > best_sum) begin
                best_idx = 2'(k);
                best_sum = corner[k];
            end
        end
    end

    p_best_not_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        best_sum >= corner[0] && best_sum >= corner[1]
        && best_sum >= corner[2] && best_sum >= corner[3]);
    p_tie_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (best_idx == 2'd3) |-> (corner[0] < corner[3] && corner[1] < corner[3]
                                && corner[2] < corner[3]));
    p_tie_order_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (best_idx == 2'd2) |-> (corner[0] < corner[2] && corner[1] < corner[2]));
endmodule

// File: rtl/csa_alloc_arbiter.sv
module csa_alloc_arbiter
    import csa_pkg::*;
#(
    parameter int CHG_W = 8,
    localparam int SUM_W = CHG_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    single_mode,
    input  logic                    coarse_mode,
    input  logic [SUM_W-1:0]        sum_thr,
    input  logic [GRID_N*CHG_W-1:0] grid_chg,
    input  logic [GRID_N-1:0]       grid_hit,
    output logic                    hit_strobe,
    output logic [1:0]              hit_corner,
    output logic [SUM_W-1:0]        hit_sum,
    output logic                    hit_over_thr
);
    logic [CHG_W-1:0] win_chg [WIN_N];
    logic             win_hit [WIN_N];
    logic             centre_wins;
    logic [1:0]       best_idx;
    logic [SUM_W-1:0] best_sum;

    csa_window_sel #(.CHG_W(CHG_W)) u_win (
        .coarse_mode(coarse_mode), .grid_chg(grid_chg), .grid_hit(grid_hit),
        .win_chg(win_chg), .win_hit(win_hit)
    );
    csa_local_max #(.CHG_W(CHG_W)) u_max (
        .clk(clk), .rst_n(rst_n), .win_chg(win_chg), .win_hit(win_hit),
        .centre_wins(centre_wins)
    );
    csa_corner_sum #(.CHG_W(CHG_W), .SUM_W(SUM_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .win_chg(win_chg),
        .best_idx(best_idx), .best_sum(best_sum)
    );

    alloc_cls_e       cls_d, cls_q;
    logic [1:0]       idx_q;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] thr_q;
    logic [CHG_W-1:0] ctr_q;

    always_comb begin
        cls_d = CLS_NONE;
        if (in_valid) begin
            if (single_mode)
                cls_d = win_hit[CTR] ? CLS_SINGLE : CLS_NONE;
            else
                cls_d = centre_wins ? CLS_SUMMED : CLS_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= CLS_NONE;
            idx_q <= '0;
            sum_q <= '0;
            thr_q <= '0;
            ctr_q <= '0;
        end else begin
            cls_q <= cls_d;
            idx_q <= best_idx;
            sum_q <= best_sum;
            thr_q <= sum_thr;
            ctr_q <= win_chg[CTR];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_strobe   <= 1'b0;
            hit_corner   <= '0;
            hit_sum      <= '0;
            hit_over_thr <= 1'b0;
        end else begin
            unique case (cls_q)
                CLS_SUMMED: begin
                    hit_strobe   <= 1'b1;
                    hit_corner   <= idx_q;
                    hit_sum      <= sum_q;
                    hit_over_thr <= (sum_q >= thr_q);
                end
                CLS_SINGLE: begin
                    hit_strobe   <= 1'b1;
                    hit_corner   <= '0;
                    hit_sum      <= SUM_W'(ctr_q);
                    hit_over_thr <= 1'b1;
                end
                default: begin
                    hit_strobe   <= 1'b0;
                    hit_corner   <= '0;
                    hit_sum      <= '0;
                    hit_over_thr <= 1'b0;
                end
            endcase
        end
    end

    p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_strobe |-> (hit_corner == 2'd0 && hit_sum == '0 && !hit_over_thr));
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> !hit_strobe);
    p_over_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q == CLS_SUMMED) |=> (hit_over_thr == (hit_sum >= $past(thr_q))));
endmodule

// File: tb/sim_csa_alloc_arbiter.sv
`timescale 1ns/1ps
module sim_csa_alloc_arbiter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         single_mode = 1'b0;
    logic         coarse_mode = 1'b0;
    logic [9:0]   sum_thr = '0;
    logic [199:0] grid_chg = '0;
    logic [24:0]  grid_hit = '0;
    logic         hit_strobe;
    logic [1:0]   hit_corner;
    logic [9:0]   hit_sum;
    logic         hit_over_thr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] gc [25];
    logic       gh [25];

    always #4 clk = ~clk;

    csa_alloc_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .single_mode(single_mode),
        .coarse_mode(coarse_mode), .sum_thr(sum_thr), .grid_chg(grid_chg),
        .grid_hit(grid_hit), .hit_strobe(hit_strobe), .hit_corner(hit_corner),
        .hit_sum(hit_sum), .hit_over_thr(hit_over_thr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_grid(input logic [7:0] c, input logic h);
        for (int i = 0; i < 25; i++) begin
            gc[i] = c;
            gh[i] = h;
        end
    endtask

    // places a 3x3 window (raster order) at the fine or coarse taps
    task automatic put_win(input logic [7:0] w [9], input logic wh [9], input bit coarse);
        for (int i = 0; i < 9; i++) begin
            int r = i / 3;
            int c = i % 3;
            int ix = coarse ? (2 * r) * 5 + 2 * c : (r + 1) * 5 + (c + 1);
            gc[ix] = w[i];
            gh[ix] = wh[i];
        end
    endtask

    task automatic run(input string req, input bit vld, input bit single, input bit coarse,
                       input int thr, input int e_stb, input int e_idx, input int e_sum,
                       input int e_ovr);
        @(negedge clk);
        for (int i = 0; i < 25; i++) begin
            grid_chg[i*8 +: 8] = gc[i];
            grid_hit[i] = gh[i];
        end
        in_valid = vld;
        single_mode = single;
        coarse_mode = coarse;
        sum_thr = 10'(thr);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "strobe after one clock", int'(hit_strobe), 0);
        @(posedge clk);
        @(negedge clk);
        chk(req, "strobe", int'(hit_strobe), e_stb);
        chk(req, "corner", int'(hit_corner), e_idx);
        chk(req, "sum", int'(hit_sum), e_sum);
        chk(req, "over_thr", int'(hit_over_thr), e_ovr);
    endtask

    logic [7:0] base [9] = '{8'd10, 8'd20, 8'd30, 8'd40, 8'd100, 8'd50, 8'd60, 8'd70, 8'd80};
    logic       all1 [9] = '{1, 1, 1, 1, 1, 1, 1, 1, 1};

    task automatic t_reset();
        chk("R1", "strobe", int'(hit_strobe), 0);
        chk("R1", "corner", int'(hit_corner), 0);
        chk("R1", "sum", int'(hit_sum), 0);
        chk("R1", "over_thr", int'(hit_over_thr), 0);
    endtask

    task automatic t_centre_max();
        // corners TL170 TR200 BL270 BR300
        fill_grid(8'd0, 1'b0);
        put_win(base, all1, 0);
        run("R2 R5", 1, 0, 0, 250, 1, 3, 300, 1);
    endtask

    task automatic t_bigger_neighbour();
        logic [7:0] w [9] = base;
        w[8] = 8'd120;
        fill_grid(8'd0, 1'b0);
        put_win(w, all1, 0);
        run("R2 R11", 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_ties();
        logic [7:0] w [9] = base;
        w[0] = 8'd100;
        fill_grid(8'd0, 1'b0);
        put_win(w, all1, 0);
        run("R3 earlier", 1, 0, 0, 0, 0, 0, 0, 0);
        w = base;
        w[8] = 8'd100;
        put_win(w, all1, 0);
        run("R3 later", 1, 0, 0, 0, 1, 3, 320, 1);
    endtask

    task automatic t_masked();
        logic [7:0] w [9] = base;
        logic       h [9] = all1;
        w[8] = 8'd255;
        h[8] = 1'b0;
        fill_grid(8'd0, 1'b0);
        put_win(w, h, 0);
        // BR becomes 220, BL 270 wins
        run("R4", 1, 0, 0, 0, 1, 2, 270, 1);
    endtask

    task automatic t_corner_ties();
        logic [7:0] w [9] = '{8'd10, 8'd10, 8'd10, 8'd10, 8'd50, 8'd10, 8'd10, 8'd10, 8'd10};
        fill_grid(8'd0, 1'b0);
        put_win(w, all1, 0);
        run("R6 all equal", 1, 0, 0, 0, 1, 0, 80, 1);
        w[2] = 8'd20;
        w[8] = 8'd20;
        put_win(w, all1, 0);
        run("R6 TR/BR tie", 1, 0, 0, 0, 1, 1, 90, 1);
    endtask

    task automatic t_threshold();
        fill_grid(8'd0, 1'b0);
        put_win(base, all1, 0);
        run("R7 equal", 1, 0, 0, 300, 1, 3, 300, 1);
        run("R7 above", 1, 0, 0, 301, 1, 3, 300, 0);
    endtask

    task automatic t_single();
        logic [7:0] w [9] = base;
        logic       h [9] = all1;
        w[8] = 8'd120;
        fill_grid(8'd0, 1'b0);
        put_win(w, h, 0);
        run("R8 bypass", 1, 1, 0, 1000, 1, 0, 100, 1);
        h[4] = 1'b0;
        put_win(w, h, 0);
        run("R8 no flag", 1, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_coarse();
        fill_grid(8'd5, 1'b1);
        put_win(base, all1, 1);
        run("R9 coarse", 1, 0, 1, 0, 1, 3, 300, 1);
        run("R9 fine", 1, 0, 0, 0, 1, 0, 115, 1);
    endtask

    task automatic t_invalid();
        fill_grid(8'd0, 1'b0);
        put_win(base, all1, 0);
        run("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_centre_max();
        t_bigger_neighbour();
        t_ties();
        t_masked();
        t_corner_ties();
        t_threshold();
        t_single();
        t_coarse();
        t_invalid();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule